// File: doc/BRIEF.md
# Four-Bit-Slice Row Multiplier with Two-Bit Carry Chain

This block multiplies an unsigned N-bit multiplicand by a 4-bit unsigned multiplier slice in a single row of identical arithmetic cells. All four multiplier bits are broadcast along the row. Each cell forms four partial-product bits at its own weight by ANDing the multiplier bits with a window of multiplicand bits. It adds those four bits to a two-bit carry from its lower neighbour and hands a two-bit carry to its upper neighbour. A single full-adder-with-one-carry step is thus replaced by a four-operand step with a wider carry. All four shifted copies of the multiplicand are summed in one pass along the row.

The row holds N+5 cells. The lowest N+4 result bits form the product. The last cell absorbs any remaining carry, so its own result bit and its carry-out are always zero. Operands are sampled on a valid strobe, and the (N+4)-bit product is held in an output register with its own valid flag one cycle later. The block is a building element that can be tiled into wider multipliers.

Top module: `quad_row_mult`

## Requirements
- R1: A synchronous active-low reset clears `res_valid` to 0 and `res_prod` to 0. This holds even if a product was loaded before the reset.
- R2: `res_valid` is 1 in exactly the cycle after a cycle in which `op_valid` was 1. Otherwise it is 0.
- R3: When `res_valid` is 1, `res_prod` equals the unsigned product of the `op_mcand` and `op_mslice` values sampled in the previous cycle. The product is zero-extended to OP_W+4 bits.
- R4: When `op_valid` is 0, `res_prod` keeps its value, whatever `op_mcand` and `op_mslice` do.
- R5: Bit k of `op_mslice` carries weight 2^k. Cell i adds the four bits mcand[i-k] AND mslice[k] for k = 0 to 3 (a multiplicand bit outside 0 to OP_W-1 counts as 0) to its two-bit carry-in. The first cell's carry-in is 0. At the maximum operands (all ones) the product is (2^OP_W-1)*15 exactly.
- R6: The row has OP_W+5 cells. For every operand pair, the topmost cell's result bit and its two-bit carry-out are 0.
- R7: A zero multiplicand or a zero multiplier slice gives a zero product.
- R8: A multiplier slice of 1 returns the multiplicand unchanged. A slice of 8 returns the multiplicand shifted left by three places.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operand strobe; operands are sampled when 1 |
| op_mcand | input | OP_W | Unsigned multiplicand |
| op_mslice | input | 4 | Unsigned 4-bit multiplier slice |
| res_valid | output | 1 | Product valid flag, one cycle after the strobe |
| res_prod | output | OP_W+4 | Registered unsigned product |

## Verification
The bench builds two copies of the block. The first uses OP_W=8, where the whole operand space of 256 by 16 pairs is small enough to sweep completely. That sweep exercises every carry pattern the two-bit chain can see at that width, including the all-ones case that drives each cell to its largest sum. The second uses OP_W=16. Random operands there reach a longer chain, with deeper carry runs that cannot occur in the narrow row, and confirm that the widths derived from the parameter still line up.

// File: rtl/qrm_pkg.sv
// Package: shared types of the four-bit-slice row multiplier.
// Assumes: used by every module of the row multiplier.
package qrm_pkg;
    // Two-bit carry passed from one cell to the next.
    typedef logic [1:0] carry2_t;
    // Width of one cell's sum: four operand bits plus carry up to 3 gives at most 7.
    localparam int CELL_SUM_W = 3;
    // Number of multiplier bits broadcast along the row.
    localparam int SLICE_W = 4;
endpackage

// File: rtl/qrm_cell.sv
// Module: qrm_cell
// One arithmetic cell of the row. It ANDs four multiplicand bits (already
// aligned to this cell's weight by the row) with the four broadcast
// multiplier bits, adds the resulting bits to a two-bit carry-in, and emits
// the low sum bit plus a two-bit carry-out.
// Assumes: win[k] is the multiplicand bit of weight (cell index - k), 0 if absent.
module qrm_cell
    import qrm_pkg::*;
(
    input  logic [SLICE_W-1:0] win,
    input  logic [SLICE_W-1:0] mslice,
    input  carry2_t            cin,
    output logic               sum_bit,
    output carry2_t            cout
);
    logic [SLICE_W-1:0]    pp;
    logic [CELL_SUM_W-1:0] total;

    // Form the four partial-product bits of this weight.
    assign pp = win & mslice;

    // Add four single bits and the two-bit carry; the result never exceeds 7.
    always_comb begin
        total = CELL_SUM_W'(pp[0]) + CELL_SUM_W'(pp[1]) + CELL_SUM_W'(pp[2])
              + CELL_SUM_W'(pp[3]) + CELL_SUM_W'(cin);
    end

    assign sum_bit = total[0];
    assign cout    = total[2:1];
endmodule

// File: rtl/qrm_row.sv
// Module: qrm_row
// Combinational row of OP_W+5 cells chained by a two-bit carry. It pads the
// multiplicand with zeros so that each cell sees a four-bit window of the
// multiplicand at its own weight, then ripples the carry from cell 0 upward.
// Assumes: unsigned operands; the first cell's carry-in is tied to 0.
module qrm_row
    import qrm_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic [OP_W-1:0]    mcand,
    input  logic [SLICE_W-1:0] mslice,
    output logic [OP_W+4:0]    row_bits,
    output carry2_t            row_carry
);
    localparam int NCELL = OP_W + 5;
    localparam int EXT_W = OP_W + 8;

    // ext[j+3] = mcand[j]; three zeros below, five above.
    logic [EXT_W-1:0] ext;
    carry2_t          chain [NCELL+1];

    assign ext      = {5'b0, mcand, 3'b0};
    assign chain[0] = 2'b00;

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        logic [SLICE_W-1:0] win;
        // Gather the multiplicand bits of weight i-k for k = 0..3.
        for (genvar k = 0; k < SLICE_W; k++) begin : g_win
            assign win[k] = ext[i + 3 - k];
        end
        qrm_cell u_cell (
            .win     (win),
            .mslice  (mslice),
            .cin     (chain[i]),
            .sum_bit (row_bits[i]),
            .cout    (chain[i+1])
        );
    end

    assign row_carry = chain[NCELL];
endmodule

// File: rtl/quad_row_mult.sv
// Module: quad_row_mult (top)
// Multiplies an OP_W-bit multiplicand by a 4-bit slice through one row of
// two-bit-carry cells and registers the (OP_W+4)-bit product on a valid strobe.
// Assumes: unsigned operands; clk rising edge; synchronous active-low reset.
module quad_row_mult
    import qrm_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [OP_W-1:0]    op_mcand,
    input  logic [SLICE_W-1:0] op_mslice,
    output logic               res_valid,
    output logic [OP_W+3:0]    res_prod
);
    localparam int PROD_W = OP_W + 4;
    localparam int NCELL  = OP_W + 5;

    logic [NCELL-1:0] row_bits;
    carry2_t          row_carry;

    qrm_row #(.OP_W(OP_W)) u_row (
        .mcand     (op_mcand),
        .mslice    (op_mslice),
        .row_bits  (row_bits),
        .row_carry (row_carry)
    );

    // Capture the row result on a strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_prod  <= '0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                res_prod <= row_bits[PROD_W-1:0];
            end
        end
    end

    // R1: the cycle after a reset edge shows cleared outputs.
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!res_valid && res_prod == '0));

    // R2: the valid flag follows the strobe by exactly one cycle.
    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == $past(op_valid && rst_n));

    // R3: a valid product matches the operands sampled one cycle earlier.
    assert_product_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_prod == (PROD_W'($past(op_mcand)) * PROD_W'($past(op_mslice))));

    // R4: without a strobe the product register keeps its value.
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(op_valid)) |-> $stable(res_prod));

    // R6: the last cell has flushed all carry; nothing spills past the product.
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> (row_bits[NCELL-1] == 1'b0 && row_carry == 2'b00));
endmodule

// File: tb/quad_row_mult_tb.sv
// Bench: table of directed vectors, exhaustive sweep at OP_W=8, random
// vectors at OP_W=16, then directed reset, valid, hold and corner tests.
module quad_row_mult_tb_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        v8 = 1'b0, v16 = 1'b0;
    logic [7:0]  a8 = '0;
    logic [15:0] a16 = '0;
    logic [3:0]  b8 = '0, b16 = '0;
    logic        rv8, rv16;
    logic [11:0] p8;
    logic [19:0] p16;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    quad_row_mult #(.OP_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(v8), .op_mcand(a8),
        .op_mslice(b8), .res_valid(rv8), .res_prod(p8));

    quad_row_mult #(.OP_W(16)) dut_w_i (
        .clk(clk), .rst_n(rst_n), .op_valid(v16), .op_mcand(a16),
        .op_mslice(b16), .res_valid(rv16), .res_prod(p16));

    // Directed vectors for OP_W=8: multiplicand, slice, expected product.
    localparam int NTAB = 10;
    localparam logic [7:0]  TA [NTAB] = '{8'd0, 8'd255, 8'd0, 8'd255, 8'd165,
                                         8'd90, 8'd1, 8'd128, 8'd255, 8'd170};
    localparam logic [3:0]  TB [NTAB] = '{4'd0, 4'd0, 4'd15, 4'd15, 4'd1,
                                         4'd8, 4'd15, 4'd15, 4'd1, 4'd5};
    localparam logic [11:0] TE [NTAB] = '{12'd0, 12'd0, 12'd0, 12'd3825, 12'd165,
                                         12'd720, 12'd15, 12'd1920, 12'd255, 12'd850};

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Strobe one operand pair into the 8-bit copy; returns at the negedge after capture.
    task automatic apply8(input logic [7:0] a, input logic [3:0] b);
        @(negedge clk);
        a8 = a; b8 = b; v8 = 1'b1;
        @(negedge clk);
        v8 = 1'b0;
    endtask

    task automatic apply16(input logic [15:0] a, input logic [3:0] b);
        @(negedge clk);
        a16 = a; b16 = b; v16 = 1'b1;
        @(negedge clk);
        v16 = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3 table of directed vectors (entries cover R5, R7, R8 corners too).
        for (int t = 0; t < NTAB; t++) begin
            apply8(TA[t], TB[t]);
            chk(p8 == TE[t], "R3 table product", 32'(p8), 32'(TE[t]));
        end

        // R3: exhaustive sweep of the 8-bit copy against a behavioural multiply.
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 16; b++) begin
                apply8(8'(a), 4'(b));
                chk(p8 == 12'(a * b), "R3 exhaustive", 32'(p8), 32'(a * b));
            end
        end

        // R3: random vectors on the 16-bit copy.
        for (int n = 0; n < 400; n++) begin
            logic [15:0] ra;
            logic [3:0]  rb;
            ra = 16'($urandom);
            rb = 4'($urandom);
            apply16(ra, rb);
            chk(p16 == 20'(ra) * 20'(rb), "R3 random w16", 32'(p16),
                32'(20'(ra) * 20'(rb)));
        end

        // R5/R6: all-ones operands at both widths, full carry flush.
        apply8(8'hFF, 4'hF);
        chk(p8 == 12'd3825, "R5 max w8", 32'(p8), 32'd3825);
        apply16(16'hFFFF, 4'hF);
        chk(p16 == 20'd983025, "R6 max w16", 32'(p16), 32'd983025);

        // R7: zero operands.
        apply16(16'hBEEF, 4'h0);
        chk(p16 == 20'd0, "R7 zero slice", 32'(p16), 32'd0);
        apply16(16'h0000, 4'hB);
        chk(p16 == 20'd0, "R7 zero mcand", 32'(p16), 32'd0);

        // R8: slice 1 passes through, slice 8 shifts by three.
        apply16(16'hA5C3, 4'h1);
        chk(p16 == 20'h0A5C3, "R8 slice one", 32'(p16), 32'h0A5C3);
        apply16(16'hA5C3, 4'h8);
        chk(p16 == 20'h52E18, "R8 slice eight", 32'(p16), 32'h52E18);

        // R2: valid high right after the strobe, low one cycle later.
        apply8(8'd200, 4'd7);
        chk(rv8 == 1'b1, "R2 valid after strobe", 32'(rv8), 32'd1);
        chk(p8 == 12'd1400, "R3 product 200x7", 32'(p8), 32'd1400);
        a8 = 8'd17; b8 = 4'd3;
        @(negedge clk);
        chk(rv8 == 1'b0, "R2 valid drops", 32'(rv8), 32'd0);
        // R4: operands changed without a strobe; product unchanged.
        chk(p8 == 12'd1400, "R4 hold", 32'(p8), 32'd1400);
        a8 = 8'd99; b8 = 4'd9;
        @(negedge clk);
        chk(p8 == 12'd1400, "R4 hold second cycle", 32'(p8), 32'd1400);

        // R1: reset clears a loaded product.
        apply8(8'd255, 4'd15);
        rst_n = 1'b0;
        @(negedge clk);
        chk(rv8 == 1'b0, "R1 reset valid", 32'(rv8), 32'd0);
        chk(p8 == 12'd0, "R1 reset product", 32'(p8), 32'd0);
        chk(p16 == 20'd0, "R1 reset product w16", 32'(p16), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end
endmodule